// File: doc/BRIEF.md
# Tuple-Split Concatenating Multiplier

This block multiplies two unsigned 14-bit operands and returns the full 28-bit product. Each operand is cut into 4-bit tuples; the top tuple carries only the two most significant bits. Every tuple of one operand is multiplied by every tuple of the other in a small 4x4 multiplier, which gives sixteen 8-bit partial products. A partial product from tuple pair (i, j), counted from zero, carries a weight of 2^(4(i+j)).

Partial products whose weights differ by a multiple of eight bit positions cannot overlap, so they are not shifted and added one at a time. They are laid side by side in shared rows by plain wiring. Terms on even diagonals go into three rows at bit offsets 0, 8, 16 and 24. Terms on odd diagonals go into four rows at offsets 4, 12 and 20. A balanced adder tree sums these seven rows, and the low 28 bits form the product.

An optional register sits after the packing stage and another at the output. A valid flag travels alongside the data through the same stages.

Top module: `tsm_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the exact unsigned product of the `op_a` and `op_b` values that were presented with the matching `in_valid`.
- R2: `out_valid` repeats `in_valid` delayed by PIPE_PP+PIPE_OUT clock cycles (two with the defaults). A product appears in the same cycle as its valid flag.
- R3: While `rst_n` is low, and for the first PIPE_PP+PIPE_OUT cycles after it rises, `out_valid` is 0 and `product` is 0.
- R4: Two all-ones operands (16383 x 16383) give 268402689 (0xFFF8001). No product ever exceeds this value.
- R5: If either operand is zero, the product is zero.
- R6: For every p and q in 0..13, the operands 2^p and 2^q give exactly 2^(p+q), which covers each tuple-pair position including the top bit 2^26.
- R7: A new operand pair may be presented on every cycle. Each pair yields its own correct product, one per cycle, with no stall.
- R8: Operands whose set bits lie only in the 2-bit top tuple (bits 13:12) multiply correctly. For example, 0x3000 x 0x3000 gives 0x9000000 and 3 x 0x3000 gives 0x9000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the operands on this cycle as a request |
| op_a | input | 14 | Unsigned multiplicand |
| op_b | input | 14 | Unsigned multiplier |
| out_valid | output | 1 | Product on `product` belongs to a request |
| product | output | 28 | Unsigned 28-bit product |

## Verification
The failure of most concern is a partial product placed in the wrong row slot, or given the wrong bit offset. Such an error is invisible for most operand pairs and shows only when the tuple pair concerned is non-zero. For that reason, the single-bit sweep drives each tuple pair alone and exposes any misplaced slot at the output two cycles later. A wrong valid delay or a stale pipeline register shows up on the first streamed pair as a mismatch between product and flag. Random and all-ones operands load every row at once and expose carry loss in the adder tree.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // Number of tuples needed to cover an operand.
    function automatic int tuple_count(int op_w, int tup_w);
        return (op_w + tup_w - 1) / tup_w;
    endfunction

    // Number of tuple pairs (i, j) with i + j == s when each index is below n.
    function automatic int diag_pairs(int s, int n);
        if (s < 0 || s > 2 * n - 2) return 0;
        return (s < n) ? s + 1 : 2 * n - 1 - s;
    endfunction

    // Rows needed for one parity class: the fullest diagonal of that parity.
    function automatic int parity_rows(int par, int n);
        int m;
        m = 0;
        for (int s = par; s <= 2 * n - 2; s += 2) begin
            if (diag_pairs(s, n) > m) m = diag_pairs(s, n);
        end
        return m;
    endfunction

endpackage

// File: rtl/tsm_tuple_mul.sv
module tsm_tuple_mul #(
    parameter int TUP_W = 4,
    localparam int PP_W = 2 * TUP_W
) (
    input  logic [TUP_W-1:0] x,
    input  logic [TUP_W-1:0] y,
    output logic [PP_W-1:0]  p
);
    // Small monolithic product: a flat 2*TUP_W-bit result.
    always_comb begin
        p = PP_W'(x) * PP_W'(y);
    end
endmodule

// File: rtl/tsm_row_pack.sv
module tsm_row_pack #(
    parameter int NTUP      = 4,
    parameter int TUP_W     = 4,
    parameter int ROWS_EVEN = 3,
    parameter int ROWS_ODD  = 4,
    localparam int PP_W   = 2 * TUP_W,
    localparam int NROWS  = ROWS_EVEN + ROWS_ODD,
    localparam int ROW_W  = 2 * TUP_W * NTUP,
    localparam int RIDX_W = (NROWS > 1) ? $clog2(NROWS) : 1
) (
    input  logic [NTUP-1:0][NTUP-1:0][PP_W-1:0] pp,
    output logic [NROWS-1:0][ROW_W-1:0]         rows
);
    // Diagonal s holds every pair with i + j == s at bit offset TUP_W*s.
    // Diagonals of one parity sit PP_W bits apart, so their terms never overlap
    // and the k-th term of each diagonal shares row k of that parity class.
    always_comb begin
        int k;
        int r;
        rows = '0;
        for (int s = 0; s < 2 * NTUP - 1; s++) begin
            k = 0;
            for (int i = 0; i < NTUP; i++) begin
                if (s - i >= 0 && s - i < NTUP) begin
                    r = ((s % 2) == 0) ? k : ROWS_EVEN + k;
                    rows[RIDX_W'(r)][TUP_W * s +: PP_W] = pp[i][s - i];
                    k++;
                end
            end
        end
    end
endmodule

// File: rtl/tsm_adder_tree.sv
module tsm_adder_tree #(
    parameter int NROWS = 7,
    parameter int ROW_W = 32,
    localparam int LEV  = (NROWS > 1) ? $clog2(NROWS) : 0,
    localparam int NPAD = 1 << LEV
) (
    input  logic [NROWS-1:0][ROW_W-1:0] rows,
    output logic [ROW_W-1:0]            sum
);
    logic [LEV:0][NPAD-1:0][ROW_W-1:0] lvl;

    // Balanced pairwise reduction; unused leaves are zero.
    always_comb begin
        lvl = '0;
        for (int r = 0; r < NROWS; r++) begin
            lvl[0][r] = rows[r];
        end
        for (int l = 0; l < LEV; l++) begin
            for (int n = 0; n < (NPAD >> (l + 1)); n++) begin
                lvl[l + 1][n] = lvl[l][2 * n] + lvl[l][2 * n + 1];
            end
        end
        sum = lvl[LEV][0];
    end
endmodule

// File: rtl/tsm_mul.sv
module tsm_mul #(
    parameter int OP_W     = 14,
    parameter int TUP_W    = 4,
    parameter bit PIPE_PP  = 1'b1,
    parameter bit PIPE_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              out_valid,
    output logic [2*OP_W-1:0] product
);
    import tsm_pkg::*;

    localparam int NTUP      = tuple_count(OP_W, TUP_W);
    localparam int EXT_W     = NTUP * TUP_W;
    localparam int PP_W      = 2 * TUP_W;
    localparam int PROD_W    = 2 * OP_W;
    localparam int ROWS_EVEN = parity_rows(0, NTUP);
    localparam int ROWS_ODD  = parity_rows(1, NTUP);
    localparam int NROWS     = ROWS_EVEN + ROWS_ODD;
    localparam int ROW_W     = 2 * TUP_W * NTUP;

    typedef struct packed {
        logic                         vld;
        logic [NROWS-1:0][ROW_W-1:0]  rows;
    } pack_stage_t;

    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] prod;
    } out_stage_t;

    logic [EXT_W-1:0] a_ext, b_ext;
    logic [NTUP-1:0][TUP_W-1:0] a_tup, b_tup;
    logic [NTUP-1:0][NTUP-1:0][PP_W-1:0] pp;
    logic [NROWS-1:0][ROW_W-1:0] packed_rows;
    logic [ROW_W-1:0] row_sum;

    pack_stage_t pk_d, pk_q;
    out_stage_t  ou_d, ou_q;

    assign a_ext = EXT_W'(op_a);
    assign b_ext = EXT_W'(op_b);

    // Tuple split and the grid of small multipliers.
    for (genvar i = 0; i < NTUP; i++) begin : g_split
        assign a_tup[i] = a_ext[i * TUP_W +: TUP_W];
        assign b_tup[i] = b_ext[i * TUP_W +: TUP_W];
    end

    for (genvar i = 0; i < NTUP; i++) begin : g_row
        for (genvar j = 0; j < NTUP; j++) begin : g_col
            tsm_tuple_mul #(.TUP_W(TUP_W)) u_tm (
                .x (a_tup[i]),
                .y (b_tup[j]),
                .p (pp[i][j])
            );
        end
    end

    tsm_row_pack #(
        .NTUP      (NTUP),
        .TUP_W     (TUP_W),
        .ROWS_EVEN (ROWS_EVEN),
        .ROWS_ODD  (ROWS_ODD)
    ) u_pack (
        .pp   (pp),
        .rows (packed_rows)
    );

    // Stage 1: packed rows.
    always_comb begin
        pk_d.vld  = in_valid;
        pk_d.rows = packed_rows;
    end

    if (PIPE_PP) begin : g_pk_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pk_q <= '0;
            else        pk_q <= pk_d;
        end
    end else begin : g_pk_thru
        always_comb pk_q = pk_d;
    end

    tsm_adder_tree #(
        .NROWS (NROWS),
        .ROW_W (ROW_W)
    ) u_tree (
        .rows (pk_q.rows),
        .sum  (row_sum)
    );

    // Stage 2: the true product never needs more than PROD_W bits.
    always_comb begin
        ou_d.vld  = pk_q.vld;
        ou_d.prod = row_sum[PROD_W-1:0];
    end

    if (PIPE_OUT) begin : g_ou_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ou_q <= '0;
            else        ou_q <= ou_d;
        end
    end else begin : g_ou_thru
        always_comb ou_q = ou_d;
    end

    assign out_valid = ou_q.vld;
    assign product   = ou_q.prod;

endmodule

// File: rtl/tsm_mul_check.sv
module tsm_mul_check #(
    parameter int OP_W = 14,
    parameter int LAT  = 2,
    localparam int PW  = 2 * OP_W,
    localparam int CW  = $clog2(LAT + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [OP_W-1:0] op_a,
    input logic [OP_W-1:0] op_b,
    input logic          out_valid,
    input logic [PW-1:0] product
);
    localparam logic [PW-1:0] ALL1 = PW'({OP_W{1'b1}});
    localparam logic [PW-1:0] MAXP = ALL1 * ALL1;

    logic [PW-1:0] exp_now;
    logic          zero_now;
    logic          exp_v, exp_z;
    logic [PW-1:0] exp_p;

    assign exp_now  = PW'(op_a) * PW'(op_b);
    assign zero_now = (op_a == '0) || (op_b == '0);

    if (LAT > 0) begin : g_line
        logic [LAT-1:0]         v_line, z_line;
        logic [LAT-1:0][PW-1:0] p_line;
        logic [CW-1:0]          since_rst;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_line    <= '0;
                z_line    <= '0;
                p_line    <= '0;
                since_rst <= '0;
            end else begin
                v_line[0] <= in_valid;
                z_line[0] <= zero_now;
                p_line[0] <= exp_now;
                for (int k = 1; k < LAT; k++) begin
                    v_line[k] <= v_line[k-1];
                    z_line[k] <= z_line[k-1];
                    p_line[k] <= p_line[k-1];
                end
                if (since_rst < CW'(LAT)) since_rst <= since_rst + 1'b1;
            end
        end

        assign exp_v = v_line[LAT-1];
        assign exp_z = z_line[LAT-1];
        assign exp_p = p_line[LAT-1];

        AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst < CW'(LAT)) |-> (!out_valid && product == '0)); // R3
    end else begin : g_comb
        assign exp_v = in_valid;
        assign exp_z = zero_now;
        assign exp_p = exp_now;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_v); // R2

    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product == exp_p); // R1

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && exp_z) |-> product == '0); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product <= MAXP); // R4

endmodule

bind tsm_mul tsm_mul_check #(
    .OP_W (OP_W),
    .LAT  (int'(PIPE_PP) + int'(PIPE_OUT))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/tsm_mul_tb.sv
`timescale 1ns/1ps
module tsm_mul_tb;
    localparam int OP_W = 14;
    localparam int PW   = 28;
    localparam int LAT  = 2;
    localparam int NVEC = 13;

    // {op_a, op_b, expected product}
    localparam logic [OP_W+OP_W+PW-1:0] VEC [NVEC] = '{
        {14'd0,     14'd0,     28'd0},
        {14'd16383, 14'd16383, 28'd268402689},
        {14'd1,     14'd16383, 28'd16383},
        {14'd16383, 14'd0,     28'd0},
        {14'd8192,  14'd8192,  28'd67108864},
        {14'd12288, 14'd12288, 28'd150994944},
        {14'd15,    14'd15,    28'd225},
        {14'd240,   14'd15,    28'd3600},
        {14'd1234,  14'd5678,  28'd7006652},
        {14'd10000, 14'd9999,  28'd99990000},
        {14'd4095,  14'd4097,  28'd16777215},
        {14'd10922, 14'd5461,  28'd59645042},
        {14'd3,     14'd12288, 28'd36864}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [OP_W-1:0] op_a = '0;
    logic [OP_W-1:0] op_b = '0;
    logic out_valid;
    logic [PW-1:0] product;

    int n_chk = 0;
    int n_bad = 0;
    int wr = 0;
    int filled = 0;
    logic          h_v [4];
    logic [PW-1:0] h_e [4];
    string         h_t [4];
    logic [31:0]   lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    tsm_mul u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .product   (product)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: check the result launched LAT cycles ago, then drive a new pair.
    task automatic push(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                        input logic v, input logic [PW-1:0] e, input string tag);
        int idx;
        @(negedge clk);
        if (filled >= LAT) begin
            idx = (wr - LAT) % 4;
            check(out_valid == h_v[idx], "R2 valid delay", PW'(out_valid), PW'(h_v[idx]));
            if (h_v[idx]) check(product == h_e[idx], h_t[idx], product, h_e[idx]);
        end
        h_v[wr % 4] = v;
        h_e[wr % 4] = e;
        h_t[wr % 4] = tag;
        in_valid = v;
        op_a = a;
        op_b = b;
        wr++;
        filled++;
    endtask

    task automatic flush();
        for (int k = 0; k < LAT; k++) push('0, '0, 1'b0, '0, "flush");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        op_a = 14'd16383;
        op_b = 14'd16383;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 valid in reset", PW'(out_valid), '0);
        check(product == '0, "R3 product in reset", product, '0);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0 && product == '0, "R3 after release", product, '0);
        in_valid = 1'b0;
        filled = 0;
    endtask

    function automatic logic [PW-1:0] mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        return PW'(a) * PW'(b);
    endfunction

    initial begin
        do_reset();

        // R1: vector table
        for (int v = 0; v < NVEC; v++) begin
            push(VEC[v][PW+OP_W +: OP_W], VEC[v][PW +: OP_W], 1'b1, VEC[v][PW-1:0], "R1 table");
        end
        flush();

        // Directed corner cases
        push(14'h3FFF, 14'h3FFF, 1'b1, 28'hFFF8001, "R4 all ones");
        push(14'd0, 14'h2D5B, 1'b1, 28'd0, "R5 zero a");
        push(14'h1F0F, 14'd0, 1'b1, 28'd0, "R5 zero b");
        push(14'h3000, 14'h3000, 1'b1, 28'h9000000, "R8 top tuple");
        push(14'd3, 14'h3000, 1'b1, 28'h0009000, "R8 top tuple low");
        push(14'h2000, 14'h1000, 1'b1, 28'h2000000, "R8 top bits");
        flush();

        // R6: single-bit sweep over every tuple-pair position
        for (int p = 0; p < OP_W; p++) begin
            for (int q = 0; q < OP_W; q++) begin
                push(OP_W'(1) << p, OP_W'(1) << q, 1'b1, PW'(1) << (p + q), "R6 single bit");
            end
        end
        flush();

        // R7: back-to-back stream with a distinct product each cycle
        for (int i = 0; i < 16; i++) begin
            push(OP_W'(i * 1000 + 7), OP_W'(16383 - i * 500), 1'b1,
                 mul(OP_W'(i * 1000 + 7), OP_W'(16383 - i * 500)), "R7 stream");
        end
        flush();

        // R2: gaps in the valid pattern
        for (int i = 0; i < 12; i++) begin
            push(OP_W'(i * 37 + 1), OP_W'(i * 91 + 3), (i % 3) != 1,
                 mul(OP_W'(i * 37 + 1), OP_W'(i * 91 + 3)), "R2 gapped");
        end
        flush();

        // R1: random operands
        for (int i = 0; i < 300; i++) begin
            logic [OP_W-1:0] ra, rb;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            ra = lfsr[OP_W-1:0];
            rb = lfsr[31:32-OP_W];
            push(ra, rb, 1'b1, mul(ra, rb), "R1 random");
        end

        // R3: reset while results are in flight
        push(14'h3FFF, 14'h1234, 1'b1, mul(14'h3FFF, 14'h1234), "R1 before reset");
        do_reset();
        push(14'd77, 14'd99, 1'b1, 28'd7623, "R1 after reset");
        push(14'd5, 14'd6, 1'b1, 28'd30, "R7 after reset");
        flush();
        push('0, '0, 1'b0, '0, "idle");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule